// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block turns 32 general-purpose input lines into four grouped interrupt requests for a main interrupt controller. Each pin passes through a two-flop synchroniser and is then XORed with a per-line sense bit, which gives the line's adjusted value. Software can read these adjusted values. A line can raise an interrupt in two ways. On the level path, the adjusted value is gated by a level enable. On the edge path, a 0-to-1 transition of the adjusted value sets a sticky pending bit, and that bit is gated by an edge enable.

Each line's interrupt cause is the OR of its level term and its edge term. The causes are ORed in groups of eight, and each group drives one registered summary output. A driver acknowledges an edge by writing the pending register: zero bits clear pending bits, and one bits leave them unchanged. To catch both edges of a line, the driver inverts that line's sense bit after each event. The block treats a sense change that takes the adjusted value from 0 to 1 as an edge.

A small register port is used for access. Writes take effect at the clock edge where the write is sampled. Read data is registered and appears one cycle after the read is sampled. Byte addresses are: 0x00 sense, 0x04 adjusted value (read-only), 0x08 edge pending, 0x0C edge enable, 0x10 level enable. Any other address reads as zero.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset, the sense, edge-enable, level-enable and edge-pending registers read zero, and all four `irq_o` bits are low.
- R2: A read of address 0x04 returns synchronised pin XOR sense. A pin change applied before clock edge N is first seen by a read sampled at edge N+2.
- R3: When line i has its level-enable bit set and its adjusted value is 1, `irq_o[i/8]` is high. When the adjusted value returns to 0, the output drops again, because the level path keeps no memory.
- R4: A 0-to-1 transition of a line's adjusted value sets its bit in the edge-pending register (0x08). The bit stays set after the pin returns to its earlier level.
- R5: With the line's sense bit at 1, a falling pin edge sets the pending bit and a rising pin edge does not.
- R6: A write to 0x08 clears each pending bit whose write-data bit is 0 and leaves each pending bit whose write-data bit is 1 unchanged.
- R7: If an edge on a line coincides with a write that clears that line's pending bit, the bit ends up set.
- R8: A sense-bit change that takes the adjusted value from 0 to 1 sets the pending bit. A change from 1 to 0 does not.
- R9: Lines 0–7, 8–15, 16–23 and 24–31 drive `irq_o[0]` to `irq_o[3]` respectively. A cause on one group leaves the other outputs low.
- R10: A pending bit is recorded even while its edge-enable bit is 0, and in that state it does not raise `irq_o`. Setting the enable bit later raises the group output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous GPIO input lines |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read |
| irq_o | output | 4 | Registered per-group interrupt requests |

## Verification
The bench drives an edge into the same clock edge as a write that clears its pending bit. A design that gave the clear priority would lose the event and read back zero. It also checks that clearing one pending bit spares the others, which catches a write that overwrites the pending register or inverts the keep/clear sense.

Sense changes are exercised in both directions. A design that ignored sense-induced edges would never record the second half of a both-edge sequence. A design that recorded 1-to-0 adjusted transitions would show a spurious pending bit.

The remaining directed tests cover three further cases. An edge that arrives while masked must stay pending and must not raise the output. Pins must map to the correct groups, so a wrong slice would light the wrong output. The synchroniser latency is checked read by read, which exposes a missing or extra stage.

// File: rtl/gic_pkg.sv
package gic_pkg;
  // Register port geometry: 32-bit words, byte addressed.
  localparam int ADDR_W = 5;
  localparam int SLOT_W = ADDR_W - 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_SENSE   = 3'd0,
    SLOT_ADJ     = 3'd1,
    SLOT_PEND    = 3'd2,
    SLOT_EDGE_EN = 3'd3,
    SLOT_LVL_EN  = 3'd4
  } slot_t;
endpackage

// File: rtl/gic_line_sync.sv
module gic_line_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/gic_edge_bank.sv
module gic_edge_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] adj_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] adj_d;
  logic [W-1:0] rise_w;
  logic [W-1:0] keep_w;

  always_ff @(posedge clk) begin
    if (rst) adj_d <= '0;
    else     adj_d <= adj_i;
  end

  assign rise_w = adj_i & ~adj_d;
  assign keep_w = clr_en ? clr_data : {W{1'b1}};

  // New edges win over a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & keep_w) | rise_w;
  end

  // R4
  edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_w != '0) |=> ((pend_q & $past(rise_w)) == $past(rise_w)));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && rise_w == '0) |=> $stable(pend_q));

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && rise_w == '0) |=> (pend_q == ($past(pend_q) & $past(clr_data))));
endmodule

// File: rtl/gic_group_or.sv
module gic_group_or #(
  parameter int W   = 32,
  parameter int GRP = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        cause_i,
  output logic [W/GRP-1:0]    irq_o
);
  localparam int NGRP = W / GRP;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (rst) irq_o[g] <= 1'b0;
        else     irq_o[g] <= |cause_i[g*GRP +: GRP];
      end
    end
  endgenerate

  // R9
  grp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gic_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int GROUP  = 8,
  parameter int STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LINES-1:0]         pin_i,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [LINES-1:0]         bus_wdata,
  input  logic                     bus_re,
  output logic [LINES-1:0]         bus_rdata,
  output logic [LINES/GROUP-1:0]   irq_o
);
  localparam int NGRP = LINES / GROUP;

  logic [LINES-1:0] pin_s;
  logic [LINES-1:0] sense_q, edge_en_q, lvl_en_q;
  logic [LINES-1:0] adj_w, pend_q, cause_w;
  slot_t            slot_w;
  logic             pend_wr;

  assign slot_w  = slot_t'(bus_addr[ADDR_W-1:2]);
  assign pend_wr = bus_we && (slot_w == SLOT_PEND);

  gic_line_sync #(.W(LINES), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_i),
    .sync_o  (pin_s)
  );

  assign adj_w = pin_s ^ sense_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q   <= '0;
      edge_en_q <= '0;
      lvl_en_q  <= '0;
    end else if (bus_we) begin
      case (slot_w)
        SLOT_SENSE:   sense_q   <= bus_wdata;
        SLOT_EDGE_EN: edge_en_q <= bus_wdata;
        SLOT_LVL_EN:  lvl_en_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  gic_edge_bank #(.W(LINES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .adj_i    (adj_w),
    .clr_en   (pend_wr),
    .clr_data (bus_wdata),
    .pend_q   (pend_q)
  );

  assign cause_w = (adj_w & lvl_en_q) | (pend_q & edge_en_q);

  gic_group_or #(.W(LINES), .GRP(GROUP)) u_grp (
    .clk     (clk),
    .rst     (rst),
    .cause_i (cause_w),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (slot_w)
        SLOT_SENSE:   bus_rdata <= sense_q;
        SLOT_ADJ:     bus_rdata <= adj_w;
        SLOT_PEND:    bus_rdata <= pend_q;
        SLOT_EDGE_EN: bus_rdata <= edge_en_q;
        SLOT_LVL_EN:  bus_rdata <= lvl_en_q;
        default:      bus_rdata <= '0;
      endcase
    end
  end

  // R3
  lvl_path_chk: assert property (@(posedge clk) disable iff (rst)
    ((adj_w & lvl_en_q) != '0) |=> (irq_o != '0));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_en_q == '0 && edge_en_q == '0) |=> (irq_o == '0));

  initial begin
    a_geom_chk: assert (LINES % GROUP == 0 && NGRP > 0);
  end
endmodule

// File: tb/tb_gpio_irq_cause.sv
module tb_gpio_irq_cause;
  localparam logic [4:0] A_SENSE = 5'h00;
  localparam logic [4:0] A_ADJ   = 5'h04;
  localparam logic [4:0] A_PEND  = 5'h08;
  localparam logic [4:0] A_EEN   = 5'h0C;
  localparam logic [4:0] A_LEN   = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_i = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int fails  = 0;

  gpio_irq_cause dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle_clear();
    idle(5);
    wr(A_PEND, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_SENSE, d); chk("R1 sense", d, 32'h0);
    rd(A_EEN, d);   chk("R1 edge_en", d, 32'h0);
    rd(A_LEN, d);   chk("R1 lvl_en", d, 32'h0);
    rd(A_PEND, d);  chk("R1 pending", d, 32'h0);
    chk("R1 irq", {28'h0, irq_o}, 32'h0);
  endtask

  task automatic t_adjusted();
    logic [31:0] d;
    pin_i = 32'hA5A5_0F0F;
    rd(A_ADJ, d); chk("R2 latency edge1", d, 32'h0);
    rd(A_ADJ, d); chk("R2 latency edge2", d, 32'h0);
    rd(A_ADJ, d); chk("R2 latency edge3", d, 32'hA5A5_0F0F);
    wr(A_SENSE, 32'hFFFF_0000);
    rd(A_ADJ, d); chk("R2 xor sense", d, 32'h5A5A_0F0F);
    wr(A_SENSE, 32'h0);
    pin_i = '0;
    settle_clear();
  endtask

  task automatic t_level();
    wr(A_LEN, 32'h0000_0008);
    pin_i = 32'h0000_0008; idle(5);
    chk("R3 level high", {28'h0, irq_o}, 32'h1);
    pin_i = '0; idle(5);
    chk("R3 level drops", {28'h0, irq_o}, 32'h0);
    wr(A_LEN, 32'hFFFF_FFFF);
    pin_i = 32'h0010_0000; idle(5);
    chk("R9 line20 group2", {28'h0, irq_o}, 32'h4);
    pin_i = 32'h8000_0000; idle(5);
    chk("R9 line31 group3", {28'h0, irq_o}, 32'h8);
    pin_i = '0;
    wr(A_LEN, 32'h0);
    settle_clear();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_EEN, 32'h0000_0200);
    pin_i = 32'h0000_1200; idle(3);
    pin_i = '0; idle(5);
    rd(A_PEND, d); chk("R4 sticky pending", d, 32'h0000_1200);
    chk("R9 line9 group1", {28'h0, irq_o}, 32'h2);
    wr(A_PEND, ~32'h0000_0200);
    rd(A_PEND, d); chk("R6 selective clear", d, 32'h0000_1000);
    idle(2);
    chk("R6 irq after clear", {28'h0, irq_o}, 32'h0);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R6 clear all", d, 32'h0);
    wr(A_EEN, 32'h0);
  endtask

  task automatic t_sense();
    logic [31:0] d;
    pin_i = 32'h0000_0020; settle_clear();
    wr(A_SENSE, 32'h0000_0020); idle(3);
    rd(A_PEND, d); chk("R8 adj 1to0 no edge", d, 32'h0);
    pin_i = 32'h0000_0000; idle(5);
    rd(A_PEND, d); chk("R5 falling caught", d, 32'h0000_0020);
    wr(A_PEND, 32'h0);
    pin_i = 32'h0000_0020; idle(5);
    rd(A_PEND, d); chk("R5 rising ignored", d, 32'h0);
    pin_i = '0; idle(5);
    wr(A_SENSE, 32'h0); idle(3);
    wr(A_PEND, 32'h0);
    wr(A_SENSE, 32'h0000_0020); idle(3);
    rd(A_PEND, d); chk("R8 sense flip edge", d, 32'h0000_0020);
    wr(A_SENSE, 32'h0);
    settle_clear();
  endtask

  task automatic t_race();
    logic [31:0] d;
    pin_i = 32'h0000_0010; idle(5);
    pin_i = 32'h0000_0014;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R7 edge beats clear", d, 32'h0000_0004);
    pin_i = '0;
    settle_clear();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pin_i = 32'h0002_0000; idle(5);
    chk("R10 masked irq low", {28'h0, irq_o}, 32'h0);
    rd(A_PEND, d); chk("R10 pending while masked", d, 32'h0002_0000);
    wr(A_EEN, 32'h0002_0000); idle(2);
    chk("R10 unmask raises", {28'h0, irq_o}, 32'h4);
    pin_i = '0;
    wr(A_EEN, 32'h0);
    settle_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_adjusted();
    t_level();
    t_edge();
    t_sense();
    t_race();
    t_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule